// File: doc/BRIEF.md
# Impulse Radio Receive Sequencer

This block steers an impulse-radio receiver through its working phases. After reset it waits for the host processor to ask for a packet. It then watches the squared input sample for energy on the channel and hands control to an external timing search. If the search finds a strong enough peak, the block waits for the demodulation template to be built. It then scans the demodulated bit stream for the start-of-frame byte, reads the length byte that follows, and emits that many payload bytes. When the last byte is out it raises a completion pulse and goes back to waiting for the host.

The correlation arithmetic, the timing search and the template averaging sit outside this block. It sees each of them only as a flag or a magnitude. Two comparisons happen here: the energy test and the correlation test. The correlation test serves twice, once on the final acquisition peak and once on the running correlation magnitude during the frame search. During the search, a weak correlation means the previous packet has ended. The block then returns to energy detection instead of waiting forever for a delimiter that will not come.

States and transitions: Idle goes to Energy on a start request. Energy goes to Acquire when energy is found. Acquire goes to Template on a passing peak, or back to Energy on a failing one. Template goes to Search when the template is done. Search goes to Length on a delimiter match, or back to Energy on a weak correlation. Length goes to Payload for a non-zero length, or to Idle for a zero length. Payload goes to Idle after the last byte.

Top module: `uwb_rx_seq`

## Requirements
- R1: After reset, state_o is 0 (idle) and len_o, byte_vld and pkt_done are 0. In idle, every input except start_req is ignored, and a high start_req moves the state to 1 (energy) at the next clock edge.
- R2: In energy (1), the state moves to 2 (acquire) at the next edge only when energy_sq is strictly greater than energy_thr. Equal or smaller values leave it in 1.
- R3: In acquire (2), the state holds until acq_done. On acq_done it goes to 3 (template) if acq_peak is strictly greater than corr_thr, and back to 1 otherwise.
- R4: In template (3), the state holds until tmpl_done, which moves it to 4 (search).
- R5: In search (4), every valid bit is shifted into an 8-bit window, oldest bit in the MSB. The window is preset to all ones on entry. A window equal to 0x55 after the shift moves the state to 5 (length), whatever the bit alignment.
- R6: In search, corr_mag strictly below corr_thr sends the state back to 1 at the next edge. This takes priority over a delimiter match in the same cycle.
- R7: The 8 valid bits after the delimiter, MSB first, form the length. len_o shows it from the edge that takes the eighth bit and holds it until the next length byte.
- R8: Each following group of 8 valid bits, MSB first, appears on byte_o with byte_vld high for exactly one cycle, starting at the edge that takes the eighth bit. No byte_vld appears in any other state.
- R9: After the number of bytes given by the length, pkt_done is high for one cycle together with the last byte_vld, and the state returns to 0. It stays in 0 until the next start_req.
- R10: A length of 0 ends the packet at once: pkt_done pulses, the state goes to 0 at the edge that takes the length byte's eighth bit, and no byte_vld is produced.
- R11: State codes on state_o are 0 idle, 1 energy, 2 acquire, 3 template, 4 search, 5 length and 6 payload. No other value ever appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Host request to receive one packet |
| energy_sq | input | EW | Squared received sample |
| energy_thr | input | EW | Energy detection threshold |
| acq_done | input | 1 | Timing search finished this cycle |
| acq_peak | input | CW | Best correlation found by the timing search |
| tmpl_done | input | 1 | Demodulation template is ready |
| bit_in | input | 1 | Demodulated bit |
| bit_vld | input | 1 | bit_in is valid this cycle |
| corr_mag | input | CW | Running absolute correlation magnitude |
| corr_thr | input | CW | Correlation threshold for peak and tail tests |
| state_o | output | 3 | Current phase code |
| len_o | output | 8 | Captured payload length |
| byte_o | output | 8 | Payload byte |
| byte_vld | output | 1 | byte_o is valid this cycle |
| pkt_done | output | 1 | Packet complete pulse to the host |

## Verification
The phase register drives state_o directly, so a wrong transition shows on that port one edge after the input that caused it. A delimiter window that is misaligned or badly preset does not show on state_o until a length is taken. It then shows as a wrong len_o and a shifted first payload byte, eight valid bits later. A byte count that is off by one shows as a missing or extra byte_vld, and as a pkt_done that comes early or late compared with the final byte. Each packet's expected bytes are queued before its bits are sent, so a byte that arrives without being expected fails at once.

// File: rtl/uwb_rx_pkg.sv
package uwb_rx_pkg;

    localparam int unsigned OCTET_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ENERGY  = 3'd1,
        ST_ACQ     = 3'd2,
        ST_TMPL    = 3'd3,
        ST_SEARCH  = 3'd4,
        ST_LEN     = 3'd5,
        ST_PAYLOAD = 3'd6
    } rx_state_t;

endpackage

// File: rtl/uwb_thr_cmp.sv
module uwb_thr_cmp #(
    parameter int unsigned W     = 16,
    parameter bit          ABOVE = 1'b1
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] limit,
    output logic         hit
);

    generate
        if (ABOVE) begin : g_above
            assign hit = value > limit;
        end else begin : g_below
            assign hit = value < limit;
        end
    endgenerate

endmodule

// File: rtl/uwb_bit_framer.sv
module uwb_bit_framer #(
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          bit_vld,
    input  logic          bit_in,
    output logic [BW-1:0] win_next,
    output logic          byte_done
);

    localparam int unsigned CNT_W = (BW > 1) ? $clog2(BW) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BW - 1);

    logic [BW-1:0]    win_q;
    logic [CNT_W-1:0] cnt_q;

    // Newest bit enters at the LSB, so the oldest bit ends up in the MSB.
    assign win_next  = {win_q[BW-2:0], bit_in};
    assign byte_done = bit_vld && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win_q <= '1;
            cnt_q <= '0;
        end else if (bit_vld) begin
            win_q <= win_next;
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/uwb_rx_fsm.sv
module uwb_rx_fsm
    import uwb_rx_pkg::*;
#(
    parameter int unsigned   BW  = 8,
    parameter logic [BW-1:0] SFD = 8'h55
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          energy_hit,
    input  logic          acq_done,
    input  logic          acq_ok,
    input  logic          tmpl_done,
    input  logic          corr_low,
    input  logic          bit_vld,
    input  logic [BW-1:0] win_next,
    input  logic          byte_done,
    output rx_state_t     state,
    output logic          framer_clr,
    output logic [BW-1:0] len_q,
    output logic [BW-1:0] byte_q,
    output logic          byte_vld,
    output logic          pkt_done
);

    rx_state_t     state_q, state_d;
    logic [BW-1:0] cnt_q;
    logic          sfd_hit;
    logic          last_byte;
    logic          len_zero;

    assign state     = state_q;
    assign sfd_hit   = (state_q == ST_SEARCH) && bit_vld && (win_next == SFD);
    assign last_byte = ({1'b0, cnt_q} + 1'b1) == {1'b0, len_q};
    assign len_zero  = (win_next == '0);

    // The bit framer runs only while bits matter; a match restarts its count.
    assign framer_clr = !(state_q inside {ST_SEARCH, ST_LEN, ST_PAYLOAD}) || sfd_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_req) state_d = ST_ENERGY;
            ST_ENERGY:  if (energy_hit) state_d = ST_ACQ;
            ST_ACQ:     if (acq_done) state_d = acq_ok ? ST_TMPL : ST_ENERGY;
            ST_TMPL:    if (tmpl_done) state_d = ST_SEARCH;
            ST_SEARCH: begin
                if (corr_low)     state_d = ST_ENERGY;
                else if (sfd_hit) state_d = ST_LEN;
            end
            ST_LEN:     if (byte_done) state_d = len_zero ? ST_IDLE : ST_PAYLOAD;
            ST_PAYLOAD: if (byte_done && last_byte) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            byte_q   <= '0;
            cnt_q    <= '0;
            byte_vld <= 1'b0;
            pkt_done <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            pkt_done <= 1'b0;
            unique case (state_q)
                ST_LEN: begin
                    if (byte_done) begin
                        len_q    <= win_next;
                        cnt_q    <= '0;
                        pkt_done <= len_zero;
                    end
                end
                ST_PAYLOAD: begin
                    if (byte_done) begin
                        byte_q   <= win_next;
                        byte_vld <= 1'b1;
                        cnt_q    <= cnt_q + 1'b1;
                        pkt_done <= last_byte;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/uwb_rx_seq.sv
module uwb_rx_seq
    import uwb_rx_pkg::*;
#(
    parameter int unsigned EW = 16,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic [EW-1:0] energy_sq,
    input  logic [EW-1:0] energy_thr,
    input  logic          acq_done,
    input  logic [CW-1:0] acq_peak,
    input  logic          tmpl_done,
    input  logic          bit_in,
    input  logic          bit_vld,
    input  logic [CW-1:0] corr_mag,
    input  logic [CW-1:0] corr_thr,
    output logic [2:0]    state_o,
    output logic [7:0]    len_o,
    output logic [7:0]    byte_o,
    output logic          byte_vld,
    output logic          pkt_done
);

    localparam int unsigned BW = OCTET_W;

    logic          energy_hit, acq_ok, corr_low;
    logic          framer_clr, byte_done;
    logic [BW-1:0] win_next;
    rx_state_t     st;

    uwb_thr_cmp #(.W(EW), .ABOVE(1'b1)) u_energy_cmp (
        .value(energy_sq), .limit(energy_thr), .hit(energy_hit)
    );

    uwb_thr_cmp #(.W(CW), .ABOVE(1'b1)) u_peak_cmp (
        .value(acq_peak), .limit(corr_thr), .hit(acq_ok)
    );

    uwb_thr_cmp #(.W(CW), .ABOVE(1'b0)) u_tail_cmp (
        .value(corr_mag), .limit(corr_thr), .hit(corr_low)
    );

    uwb_bit_framer #(.BW(BW)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (framer_clr),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .win_next (win_next),
        .byte_done(byte_done)
    );

    uwb_rx_fsm #(.BW(BW), .SFD(8'h55)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .energy_hit(energy_hit),
        .acq_done  (acq_done),
        .acq_ok    (acq_ok),
        .tmpl_done (tmpl_done),
        .corr_low  (corr_low),
        .bit_vld   (bit_vld),
        .win_next  (win_next),
        .byte_done (byte_done),
        .state     (st),
        .framer_clr(framer_clr),
        .len_q     (len_o),
        .byte_q    (byte_o),
        .byte_vld  (byte_vld),
        .pkt_done  (pkt_done)
    );

    assign state_o = st;

endmodule

// File: rtl/uwb_rx_seq_chk.sv
module uwb_rx_seq_chk #(
    parameter int unsigned EW = 16,
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_req,
    input logic [EW-1:0] energy_sq,
    input logic [EW-1:0] energy_thr,
    input logic          acq_done,
    input logic [CW-1:0] acq_peak,
    input logic          tmpl_done,
    input logic [CW-1:0] corr_mag,
    input logic [CW-1:0] corr_thr,
    input logic [2:0]    state_o,
    input logic          byte_vld,
    input logic          pkt_done
);

    a_r1_idle_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && !start_req) |=> (state_o == 3'd0));

    a_r2_energy_go: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && energy_sq > energy_thr) |=> (state_o == 3'd2));

    a_r3_acq_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && acq_done && acq_peak <= corr_thr) |=> (state_o == 3'd1));

    a_r4_tmpl_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && !tmpl_done) |=> (state_o == 3'd3));

    a_r6_tail_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && corr_mag < corr_thr) |=> (state_o == 3'd1));

    a_r8_vld_place: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> (state_o == 3'd6 || (state_o == 3'd0 && pkt_done)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (state_o == 3'd0));

    a_r11_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 3'd7);

endmodule

bind uwb_rx_seq uwb_rx_seq_chk #(.EW(EW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .energy_sq (energy_sq),
    .energy_thr(energy_thr),
    .acq_done  (acq_done),
    .acq_peak  (acq_peak),
    .tmpl_done (tmpl_done),
    .corr_mag  (corr_mag),
    .corr_thr  (corr_thr),
    .state_o   (state_o),
    .byte_vld  (byte_vld),
    .pkt_done  (pkt_done)
);

// File: tb/uwb_rx_seq_tb.sv
module uwb_rx_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic [15:0] energy_sq = '0;
    logic [15:0] energy_thr = 16'd100;
    logic        acq_done = 1'b0;
    logic [15:0] acq_peak = '0;
    logic        tmpl_done = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_vld = 1'b0;
    logic [15:0] corr_mag = 16'd200;
    logic [15:0] corr_thr = 16'd50;
    logic [2:0]  state_o;
    logic [7:0]  len_o, byte_o;
    logic        byte_vld, pkt_done;

    int total = 0;
    int bad = 0;
    int pkt_seen = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    uwb_rx_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .energy_sq(energy_sq), .energy_thr(energy_thr),
        .acq_done(acq_done), .acq_peak(acq_peak), .tmpl_done(tmpl_done),
        .bit_in(bit_in), .bit_vld(bit_vld),
        .corr_mag(corr_mag), .corr_thr(corr_thr),
        .state_o(state_o), .len_o(len_o), .byte_o(byte_o),
        .byte_vld(byte_vld), .pkt_done(pkt_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        bit_in  = b;
        bit_vld = 1'b1;
        step();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic to_search();
        start_req = 1'b1; step(); start_req = 1'b0;
        energy_sq = 16'd300; step(); energy_sq = '0;
        acq_peak = 16'd60; acq_done = 1'b1; step(); acq_done = 1'b0;
        tmpl_done = 1'b1; step(); tmpl_done = 1'b0;
        chk(state_o == 3'd4, "R4 reach search", state_o, 4);
    endtask

    // Scoreboard monitor: every byte_vld must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected byte", byte_o, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    chk(byte_o == e, "R8 payload byte", byte_o, e);
                end
            end
            if (pkt_done) pkt_seen++;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset values
        chk(state_o == 3'd0, "R1 reset state", state_o, 0);
        chk(len_o == 8'd0 && !byte_vld && !pkt_done, "R1 reset outputs", len_o, 0);

        // R1 idle ignores everything but start_req
        energy_sq = 16'd500; acq_done = 1'b1; acq_peak = 16'd90; tmpl_done = 1'b1;
        repeat (3) step();
        chk(state_o == 3'd0, "R1 idle ignores inputs", state_o, 0);
        energy_sq = '0; acq_done = 1'b0; acq_peak = '0; tmpl_done = 1'b0;

        start_req = 1'b1; step(); start_req = 1'b0;
        chk(state_o == 3'd1, "R1 start to energy", state_o, 1);

        // R2 strict energy comparison
        energy_sq = 16'd100; repeat (2) step();
        chk(state_o == 3'd1, "R2 equal energy holds", state_o, 1);
        energy_sq = 16'd101; step(); energy_sq = '0;
        chk(state_o == 3'd2, "R2 energy above", state_o, 2);

        // R3 acquisition wait, fail, then pass
        step();
        chk(state_o == 3'd2, "R3 acquire waits", state_o, 2);
        acq_peak = 16'd50; acq_done = 1'b1; step(); acq_done = 1'b0;
        chk(state_o == 3'd1, "R3 failing peak", state_o, 1);
        energy_sq = 16'd200; step(); energy_sq = '0;
        acq_peak = 16'd51; acq_done = 1'b1; step(); acq_done = 1'b0;
        chk(state_o == 3'd3, "R3 passing peak", state_o, 3);

        // R4 template wait
        step();
        chk(state_o == 3'd3, "R4 template waits", state_o, 3);
        tmpl_done = 1'b1; step(); tmpl_done = 1'b0;
        chk(state_o == 3'd4, "R4 to search", state_o, 4);

        // Packet 1: aligned frame, length 3
        exp_q.push_back(8'h01); exp_q.push_back(8'h02); exp_q.push_back(8'h03);
        repeat (4) send_byte(8'hFF);
        send_byte(8'h55);
        bit_vld = 1'b0;
        chk(state_o == 3'd5, "R5 aligned delimiter", state_o, 5);
        step();
        send_byte(8'h03);
        chk(len_o == 8'd3, "R7 length 3", len_o, 3);
        chk(state_o == 3'd6, "R11 payload code", state_o, 6);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
        bit_vld = 1'b0;
        chk(pkt_done && byte_vld, "R9 done with last byte", {pkt_done, byte_vld}, 3);
        chk(state_o == 3'd0, "R9 back to idle", state_o, 0);
        step();
        chk(!pkt_done, "R9 done is one cycle", pkt_done, 0);
        chk(exp_q.size() == 0 && pkt_seen == 1, "R8 packet 1 complete", exp_q.size(), 0);

        // Packet 2: delimiter off byte alignment, length 2
        to_search();
        exp_q.push_back(8'hAA); exp_q.push_back(8'hBB);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        send_byte(8'h55);
        chk(state_o == 3'd5, "R5 unaligned delimiter", state_o, 5);
        send_byte(8'h02);
        chk(len_o == 8'd2, "R7 length 2", len_o, 2);
        send_byte(8'hAA); send_byte(8'hBB);
        bit_vld = 1'b0;
        chk(state_o == 3'd0 && pkt_done, "R9 packet 2 end", state_o, 0);
        step();
        chk(exp_q.size() == 0 && pkt_seen == 2, "R8 packet 2 complete", pkt_seen, 2);

        // R6 weak correlation wins over a delimiter completing in the same cycle
        to_search();
        send_byte(8'hFF);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        corr_mag = 16'd10;
        send_bit(1'b1);
        bit_vld = 1'b0;
        chk(state_o == 3'd1, "R6 tail drops to energy", state_o, 1);
        corr_mag = 16'd200;
        step();
        chk(state_o == 3'd1 && !byte_vld, "R6 stays in energy", state_o, 1);
        energy_sq = 16'd200; step(); energy_sq = '0;
        acq_peak = 16'd60; acq_done = 1'b1; step(); acq_done = 1'b0;
        tmpl_done = 1'b1; step(); tmpl_done = 1'b0;

        // R10 zero length packet
        chk(state_o == 3'd4, "R10 in search", state_o, 4);
        send_byte(8'h55);
        send_byte(8'h00);
        bit_vld = 1'b0;
        chk(pkt_done && !byte_vld, "R10 immediate done", {pkt_done, byte_vld}, 2);
        chk(state_o == 3'd0 && len_o == 8'd0, "R10 idle with zero length", len_o, 0);
        step();

        // R9 idle ignores bits until a new start
        send_byte(8'h55); send_byte(8'h01); send_byte(8'h77);
        bit_vld = 1'b0;
        repeat (2) step();
        chk(state_o == 3'd0, "R9 idle ignores bits", state_o, 0);
        chk(len_o == 8'd0, "R7 length held", len_o, 0);
        chk(pkt_seen == 3 && exp_q.size() == 0, "R9 packet count", pkt_seen, 3);

        finish_run();
    end

endmodule